// File: doc/BRIEF.md
# Load-Use Stall and Taken-Branch Flush Controller

This block decides, cycle by cycle, whether the front of a five-stage in-order pipeline must freeze or be squashed. It compares the two source register indices of the instruction sitting in decode with the destination index of the instruction in execute. When the execute instruction is a load whose result the decode instruction needs, the program counter and the decode register hold for one cycle and a bubble enters execute. When execute reports a taken branch, the two younger instructions, in decode and in fetch, are discarded.

The controller is delivered with the three front-end registers it steers: the program counter, the decode register (fetch PC and instruction word) and the execute register (load flag, register-write flag, memory-write flag and destination index). All three are built from one reusable stage register with hold and clear inputs. The execute register feeds the load flag and destination back into the detector, so a stall clears its own cause. Every pin is plain control or data sampled on the clock. There is no valid/ready handshake, because nothing here applies back-pressure beyond the stall outputs themselves.

Top module: `hzc_top`

## Requirements
- R1: When the execute register holds a load with a nonzero destination equal to either decode source index, and no branch is taken, `stall_pc` and `stall_dec` are 1 in that cycle.
- R2: No stall and no hazard-driven execute flush is raised when the execute destination index is zero, whatever the sources.
- R3: On a stall edge, `pc_q`, `dec_pc_q` and `dec_insn_q` keep their values, and the execute register loads a bubble: load, register-write and memory-write flags 0 and destination 0.
- R4: A stall never lasts more than one cycle per load: in the cycle after a stall, `stall_pc` is 0.
- R5: When `taken_e` is 1, on the next edge the decode register holds PC 0 and the no-operation word 32'h0000_0013, and the execute register holds a bubble.
- R6: When a taken branch and a load-use hazard coincide, the branch wins: `stall_pc` and `stall_dec` stay 0 and `pc_q` loads `pc_next`.
- R7: `flush_exe` is 1 exactly when a load-use hazard exists or `taken_e` is 1; `flush_dec` equals `taken_e`.
- R8: With no hazard and no taken branch, on each edge `pc_q` loads `pc_next`, the decode register loads the old `pc_q` with `fetch_word`, and the execute register loads the decode bundle inputs.
- R9: A synchronous reset sets `pc_q` and `dec_pc_q` to 0, `dec_insn_q` to the no-operation word and all execute register fields to 0.
- R10: In the stage register, clear loads the reset value and overrides hold; hold alone keeps the contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_next | input | PC_W | Next fetch address |
| fetch_word | input | INSN_W | Instruction word fetched at `pc_q` |
| dec_src1 | input | IDX_W | First source index of decode instruction |
| dec_src2 | input | IDX_W | Second source index of decode instruction |
| dec_dst | input | IDX_W | Destination index of decode instruction |
| dec_load | input | 1 | Decode instruction is a load |
| dec_regwr | input | 1 | Decode instruction writes a register |
| dec_memwr | input | 1 | Decode instruction writes memory |
| taken_e | input | 1 | Branch in execute is taken |
| stall_pc | output | 1 | Hold the program counter |
| stall_dec | output | 1 | Hold the decode register |
| flush_dec | output | 1 | Clear the decode register to a no-op |
| flush_exe | output | 1 | Clear the execute register to a bubble |
| pc_q | output | PC_W | Program counter |
| dec_pc_q | output | PC_W | PC held in decode register |
| dec_insn_q | output | INSN_W | Instruction held in decode register |
| exe_dst_q | output | IDX_W | Destination index in execute register |
| exe_load_q | output | 1 | Load flag in execute register |
| exe_regwr_q | output | 1 | Register-write flag in execute register |
| exe_memwr_q | output | 1 | Memory-write flag in execute register |

## Verification
With a reduced index width, the bench sweeps every execute destination, every load flag, every pair of decode sources and both branch outcomes, so matches on the first source, on the second, on both and on neither are each seen against zero and nonzero destinations. Pairing each load setup with a taken branch separates a plain flush from a stall and shows that the branch overrides the stall. The cycle after every setup confirms that a stall clears itself through the bubble. A second, free-standing stage register is driven through all hold and clear combinations to tell hold, load and clear priority apart.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  // Encoding of the do-nothing instruction loaded by a flush.
  localparam logic [31:0] NOP_INSN = 32'h0000_0013;
  // Number of decode source operands compared against execute.
  localparam int SRC_CNT = 2;
endpackage

// File: rtl/hzc_stage_reg.sv
module hzc_stage_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= RST_VAL;
    else if (!hold) q <= d;
  end

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == RST_VAL));
  assert_hold_keeps_R10: assert property (@(posedge clk) disable iff (rst)
    (hold && !clr) |=> (q == $past(q)));
endmodule

// File: rtl/hzc_loaduse_detect.sv
module hzc_loaduse_detect #(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] src1,
  input  logic [IDX_W-1:0] src2,
  input  logic [IDX_W-1:0] dst,
  input  logic             is_load,
  output logic             hit
);
  localparam int NSRC = hzc_pkg::SRC_CNT;
  logic [NSRC-1:0] match;
  logic [IDX_W-1:0] srcs [NSRC];
  logic dst_live;

  assign srcs[0] = src1;
  assign srcs[1] = src2;
  assign dst_live = |dst;

  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    assign match[g] = (srcs[g] == dst);
  end

  assign hit = is_load && dst_live && (|match);

  always_comb begin
    if (dst == '0) assert_zero_dst_R2: assert (!hit);
  end
endmodule

// File: rtl/hzc_arbiter.sv
module hzc_arbiter (
  input  logic hit,
  input  logic taken,
  output logic stall_pc,
  output logic stall_dec,
  output logic flush_dec,
  output logic flush_exe
);
  logic stall_ok;

  assign stall_ok  = hit && !taken;
  assign stall_pc  = stall_ok;
  assign stall_dec = stall_ok;
  assign flush_dec = taken;
  assign flush_exe = hit || taken;

  always_comb begin
    if (taken) assert_branch_wins_R6: assert (!stall_pc && !stall_dec);
  end
endmodule

// File: rtl/hzc_top.sv
module hzc_top #(
  parameter int PC_W   = 32,
  parameter int INSN_W = 32,
  parameter int IDX_W  = 5,
  parameter logic [INSN_W-1:0] NOP_WORD = INSN_W'(hzc_pkg::NOP_INSN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   pc_next,
  input  logic [INSN_W-1:0] fetch_word,
  input  logic [IDX_W-1:0]  dec_src1,
  input  logic [IDX_W-1:0]  dec_src2,
  input  logic [IDX_W-1:0]  dec_dst,
  input  logic              dec_load,
  input  logic              dec_regwr,
  input  logic              dec_memwr,
  input  logic              taken_e,
  output logic              stall_pc,
  output logic              stall_dec,
  output logic              flush_dec,
  output logic              flush_exe,
  output logic [PC_W-1:0]   pc_q,
  output logic [PC_W-1:0]   dec_pc_q,
  output logic [INSN_W-1:0] dec_insn_q,
  output logic [IDX_W-1:0]  exe_dst_q,
  output logic              exe_load_q,
  output logic              exe_regwr_q,
  output logic              exe_memwr_q
);
  localparam int DEC_W = PC_W + INSN_W;
  localparam int EXE_W = IDX_W + 3;
  localparam logic [DEC_W-1:0] DEC_NOP = {{PC_W{1'b0}}, NOP_WORD};

  logic hit;
  logic [DEC_W-1:0] dec_d, dec_q;
  logic [EXE_W-1:0] exe_d, exe_q;

  hzc_loaduse_detect #(.IDX_W(IDX_W)) det_i (
    .src1(dec_src1), .src2(dec_src2), .dst(exe_dst_q),
    .is_load(exe_load_q), .hit(hit)
  );

  hzc_arbiter arb_i (
    .hit(hit), .taken(taken_e),
    .stall_pc(stall_pc), .stall_dec(stall_dec),
    .flush_dec(flush_dec), .flush_exe(flush_exe)
  );

  hzc_stage_reg #(.W(PC_W), .RST_VAL('0)) pc_reg_i (
    .clk(clk), .rst(rst), .hold(stall_pc), .clr(1'b0),
    .d(pc_next), .q(pc_q)
  );

  assign dec_d = {pc_q, fetch_word};
  hzc_stage_reg #(.W(DEC_W), .RST_VAL(DEC_NOP)) dec_reg_i (
    .clk(clk), .rst(rst), .hold(stall_dec), .clr(flush_dec),
    .d(dec_d), .q(dec_q)
  );
  assign dec_pc_q   = dec_q[DEC_W-1:INSN_W];
  assign dec_insn_q = dec_q[INSN_W-1:0];

  assign exe_d = {dec_load, dec_regwr, dec_memwr, dec_dst};
  hzc_stage_reg #(.W(EXE_W), .RST_VAL('0)) exe_reg_i (
    .clk(clk), .rst(rst), .hold(1'b0), .clr(flush_exe),
    .d(exe_d), .q(exe_q)
  );
  assign exe_load_q  = exe_q[EXE_W-1];
  assign exe_regwr_q = exe_q[EXE_W-2];
  assign exe_memwr_q = exe_q[EXE_W-3];
  assign exe_dst_q   = exe_q[IDX_W-1:0];

  assert_single_stall_R4: assert property (@(posedge clk) disable iff (rst)
    stall_pc |=> !stall_pc);
  assert_pc_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    stall_pc |=> (pc_q == $past(pc_q)));
  assert_bubble_R3: assert property (@(posedge clk) disable iff (rst)
    flush_exe |=> (!exe_load_q && !exe_regwr_q && !exe_memwr_q && exe_dst_q == '0));
  assert_dec_squash_R5: assert property (@(posedge clk) disable iff (rst)
    taken_e |=> (dec_insn_q == NOP_WORD && dec_pc_q == '0));
endmodule

// File: tb/hzc_top_tb_top.sv
module hzc_top_tb_top;
  localparam int PC_W = 32;
  localparam int INSN_W = 32;
  localparam int IDX_W = 3;
  localparam logic [31:0] NOP = 32'h0000_0013;
  localparam int NIDX = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [PC_W-1:0] pc_next = '0;
  logic [INSN_W-1:0] fetch_word = '0;
  logic [IDX_W-1:0] dec_src1 = '0, dec_src2 = '0, dec_dst = '0;
  logic dec_load = 0, dec_regwr = 0, dec_memwr = 0, taken_e = 0;
  logic stall_pc, stall_dec, flush_dec, flush_exe;
  logic [PC_W-1:0] pc_q, dec_pc_q;
  logic [INSN_W-1:0] dec_insn_q;
  logic [IDX_W-1:0] exe_dst_q;
  logic exe_load_q, exe_regwr_q, exe_memwr_q;

  hzc_top #(.PC_W(PC_W), .INSN_W(INSN_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .pc_next(pc_next), .fetch_word(fetch_word),
    .dec_src1(dec_src1), .dec_src2(dec_src2), .dec_dst(dec_dst),
    .dec_load(dec_load), .dec_regwr(dec_regwr), .dec_memwr(dec_memwr),
    .taken_e(taken_e), .stall_pc(stall_pc), .stall_dec(stall_dec),
    .flush_dec(flush_dec), .flush_exe(flush_exe), .pc_q(pc_q),
    .dec_pc_q(dec_pc_q), .dec_insn_q(dec_insn_q), .exe_dst_q(exe_dst_q),
    .exe_load_q(exe_load_q), .exe_regwr_q(exe_regwr_q), .exe_memwr_q(exe_memwr_q)
  );

  logic r_hold = 0, r_clr = 0;
  logic [7:0] r_d = '0, r_q;
  hzc_stage_reg #(.W(8), .RST_VAL(8'h5A)) reg_i (
    .clk(clk), .rst(rst), .hold(r_hold), .clr(r_clr), .d(r_d), .q(r_q)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model of the front-end registers
  logic [PC_W-1:0] m_pc, m_dpc;
  logic [INSN_W-1:0] m_dw;
  logic [IDX_W+2:0] m_exe;

  task automatic edge_model(input bit stall, input bit fd, input bit fe,
                            input logic [IDX_W+2:0] bundle);
    if (fd) begin m_dpc = '0; m_dw = NOP; end
    else if (!stall) begin m_dpc = m_pc; m_dw = fetch_word; end
    if (!stall) m_pc = pc_next;
    m_exe = fe ? '0 : bundle;
  endtask

  task automatic chk_regs(input string req);
    chk(req, pc_q, m_pc);
    chk(req, dec_pc_q, m_dpc);
    chk(req, dec_insn_q, m_dw);
    chk(req, {exe_load_q, exe_regwr_q, exe_memwr_q, exe_dst_q}, m_exe);
  endtask

  initial begin
    int idx;
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset contents
    chk("R9", pc_q, 0);
    chk("R9", dec_pc_q, 0);
    chk("R9", dec_insn_q, NOP);
    chk("R9", {exe_load_q, exe_regwr_q, exe_memwr_q, exe_dst_q}, 0);
    chk("R10", r_q, 8'h5A);
    m_pc = '0; m_dpc = '0; m_dw = NOP; m_exe = '0;
    @(negedge clk);
    rst = 0;

    idx = 0;
    for (int d = 0; d < NIDX; d++)
      for (int l = 0; l < 2; l++)
        for (int a = 0; a < NIDX; a++)
          for (int b = 0; b < NIDX; b++)
            for (int t = 0; t < 2; t++) begin
              bit haz, stl;
              logic [IDX_W+2:0] bnd;
              idx++;
              // setup phase: load {d,l} into execute
              @(negedge clk);
              pc_next = 32'h1000_0000 + idx * 8;
              fetch_word = 32'hA000_0000 + idx * 2;
              dec_dst = IDX_W'(d); dec_load = l[0]; dec_regwr = 1; dec_memwr = 0;
              dec_src1 = '0; dec_src2 = '0; taken_e = 0;
              #1;
              chk("R4", stall_pc, 0);
              chk("R8", flush_exe, 0);
              bnd = {l[0], 1'b1, 1'b0, IDX_W'(d)};
              edge_model(0, 0, 0, bnd);
              @(posedge clk); #1;
              chk_regs("R8");
              // test phase
              @(negedge clk);
              pc_next = 32'h2000_0000 + idx * 8;
              fetch_word = 32'hB000_0000 + idx * 2;
              dec_dst = IDX_W'(1); dec_load = 0; dec_regwr = 1; dec_memwr = 1;
              dec_src1 = IDX_W'(a); dec_src2 = IDX_W'(b); taken_e = t[0];
              haz = (l == 1) && (d != 0) && (a == d || b == d);
              stl = haz && (t == 0);
              #1;
              if (d == 0) chk("R2", stall_pc, 0);
              if (t == 1) chk("R6", {stall_pc, stall_dec}, 0);
              else chk("R1", {stall_pc, stall_dec}, {stl, stl});
              chk("R7", flush_exe, haz || t == 1);
              chk("R7", flush_dec, t[0]);
              bnd = {1'b0, 1'b1, 1'b1, IDX_W'(1)};
              edge_model(stl, t[0], haz || t == 1, bnd);
              @(posedge clk); #1;
              if (t == 1) chk_regs("R5");
              else if (stl) chk_regs("R3");
              else chk_regs("R8");
            end

    // R10: free-standing stage register sweep of hold/clear
    begin
      logic [7:0] mq;
      @(negedge clk);
      mq = r_q;
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        r_hold = k[0]; r_clr = k[1];
        r_d = 8'(8'h11 * k + 3);
        if (r_clr) mq = 8'h5A;
        else if (!r_hold) mq = r_d;
        @(posedge clk); #1;
        chk("R10", r_q, mq);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule